// File: doc/BRIEF.md
# Pedestal Subtraction with Zero and Overflow Suppression

This block corrects raw ADC samples for each channel. It keeps one small pedestal value for every channel. When pedestal correction is enabled, it subtracts that channel's pedestal from the incoming 11-bit sample. It registers the corrected value together with two flags. One flag marks a result that was clamped to zero. The other marks a sample that reached the overflow limit of the selected converter resolution. Downstream readout logic uses the flags to drop empty or saturated channels.

The pedestal table is loaded and inspected over a simple host port. The port works only while the module reports the ready state. While the module is busy converting, host requests are refused and the table cannot change. The correction datapath runs every cycle. The result appears on the outputs one clock after the channel address and sample are presented.

Top module: `ped_sub_unit`

## Requirements
- R1: After reset, `corr_value`, `zero_flag`, `ovf_flag`, `host_ack` and `host_rdata` are 0, and every pedestal entry reads back as 0.
- R2: While `busy` is 0, a host write stores `host_wdata` at entry `host_addr` (0 to 15). A host read returns the stored byte on `host_rdata` one clock later, with `host_ack` high for that clock.
- R3: While `busy` is 1, host writes and reads are refused. One clock later `host_ack` is 0 and `host_rdata` is 0, and the addressed entry keeps its previous value.
- R4: With `ped_en` = 1, no overflow and a sample above the channel's pedestal, `corr_value` equals the sample minus the pedestal.
- R5: With `ped_en` = 0, zero is subtracted, so `corr_value` equals the sample whenever the sample is nonzero and not in overflow.
- R6: A sample that is not in overflow and is less than or equal to the subtracted amount gives `corr_value` = 0 and `zero_flag` = 1. `zero_flag` and `ovf_flag` are never both high.
- R7: `res_sel` picks the overflow limit: 0 = 8-bit (256), 1 = 9-bit (512), 2 = 10-bit (1024), 3 = 11-bit (1920). A sample at or above the limit gives `ovf_flag` = 1, `zero_flag` = 0 and `corr_value` = 2047.
- R8: Overflow is judged on the raw sample before subtraction. A sample at or above the limit overflows even when sample minus pedestal is below the limit.
- R9: The outputs reflect `ch_addr`, `adc_data`, `ped_en` and `res_sel` as sampled at the previous rising clock edge. They do not change between edges. The correction uses the pedestal held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | 1 = module busy (host access refused), 0 = ready |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 4 | Pedestal entry for host access |
| host_wdata | input | 8 | Pedestal byte to write |
| host_rdata | output | 8 | Pedestal byte read (0 when no read or refused) |
| host_ack | output | 1 | Host request accepted in the previous cycle |
| ch_addr | input | 4 | Channel whose sample is being corrected |
| adc_data | input | 11 | Raw ADC sample |
| ped_en | input | 1 | 1 = subtract the stored pedestal, 0 = subtract zero |
| res_sel | input | 2 | Resolution select (sets the overflow limit) |
| corr_value | output | 11 | Corrected value, or 2047 on overflow |
| zero_flag | output | 1 | Result clamped to zero |
| ovf_flag | output | 1 | Sample at or above the overflow limit |

## Verification
The hardest case to reach from the ports is a sample that overflows on its raw value even though the difference after subtraction sits below the limit. Reaching it needs a large pedestal already loaded, an 8-bit limit selected and a sample just over 256. The stimulus first loads distinct pedestals into all sixteen entries during the ready state. It then uses the largest one with a sample of 300.

The other delicate case is the boundary where the sample equals the pedestal. The stimulus loads 255 into one entry and presents samples of 255 and 256 against it. Together these pin down both the zero clamp and the 8-bit overflow edge.

// File: rtl/ped_pkg.sv
package ped_pkg;
    localparam int ADC_W     = 11;
    localparam int PED_W     = 8;
    localparam int CH_N      = 16;
    localparam int ADDR_W    = $clog2(CH_N);
    localparam int RES_W     = 2;
    localparam int BASE_BITS = 8;
    localparam int TOP_LIMIT = 1920;

    typedef struct packed {
        logic [ADC_W-1:0] value;
        logic             zero;
        logic             ovf;
    } corr_t;

    // Overflow limit for a resolution code; the widest setting stops short of full scale.
    function automatic logic [ADC_W-1:0] ovf_limit(input logic [RES_W-1:0] res);
        logic [ADC_W-1:0] lim;
        if (res == RES_W'((1 << RES_W) - 1))
            lim = ADC_W'(TOP_LIMIT);
        else
            lim = ADC_W'(1) << (BASE_BITS + int'(res));
        return lim;
    endfunction
endpackage

// File: rtl/ped_store.sv
module ped_store
    import ped_pkg::*;
#(
    parameter int N_CH  = CH_N,
    parameter int DW    = PED_W,
    localparam int AW   = $clog2(N_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ack,
    input  logic [AW-1:0] look_addr,
    output logic [DW-1:0] look_ped
);
    typedef struct packed {
        logic [N_CH-1:0][DW-1:0] mem;
        logic [DW-1:0]           rdata;
        logic                    ack;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        s_d.rdata = '0;
        if (!busy) begin
            if (host_wr)
                s_d.mem[host_addr] = host_wdata;
            if (host_rd)
                s_d.rdata = s_q.mem[host_addr];
            s_d.ack = host_wr | host_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_rdata = s_q.rdata;
    assign host_ack   = s_q.ack;
    assign look_ped   = s_q.mem[look_addr];

    // R3: a busy cycle leaves the table untouched and acknowledges nothing
    p_busy_keeps_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (s_q.mem == $past(s_q.mem)));
    p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!host_ack && host_rdata == '0));
    // R2: an idle ready cycle never acknowledges
    p_idle_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |=> !host_ack);
endmodule

// File: rtl/ped_correct.sv
module ped_correct
    import ped_pkg::*;
#(
    parameter int AW = ADC_W,
    parameter int PW = PED_W
) (
    input  logic [AW-1:0]    adc,
    input  logic [PW-1:0]    ped,
    input  logic             ped_en,
    input  logic [RES_W-1:0] res_sel,
    output corr_t            result
);
    logic [AW-1:0] sub_amt;
    logic [AW-1:0] limit;

    always_comb begin
        sub_amt      = ped_en ? AW'(ped) : '0;
        limit        = ovf_limit(res_sel);
        result       = '0;
        if (adc >= limit) begin
            result.value = '1;
            result.ovf   = 1'b1;
        end else if (adc <= sub_amt) begin
            result.zero  = 1'b1;
        end else begin
            result.value = adc - sub_amt;
        end
    end
endmodule

// File: rtl/ped_sub_unit.sv
module ped_sub_unit
    import ped_pkg::*;
#(
    parameter int N_CH = CH_N,
    parameter int DW   = PED_W,
    parameter int SW   = ADC_W,
    localparam int AW  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_ack,
    input  logic [AW-1:0]    ch_addr,
    input  logic [SW-1:0]    adc_data,
    input  logic             ped_en,
    input  logic [RES_W-1:0] res_sel,
    output logic [SW-1:0]    corr_value,
    output logic             zero_flag,
    output logic             ovf_flag
);
    logic [DW-1:0] ch_ped;
    corr_t         out_d, out_q;

    ped_store #(.N_CH(N_CH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .host_ack  (host_ack),
        .look_addr (ch_addr),
        .look_ped  (ch_ped)
    );

    ped_correct #(.AW(SW), .PW(DW)) u_correct (
        .adc    (adc_data),
        .ped    (ch_ped),
        .ped_en (ped_en),
        .res_sel(res_sel),
        .result (out_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign corr_value = out_q.value;
    assign zero_flag  = out_q.zero;
    assign ovf_flag   = out_q.ovf;

    // R7: overflow always carries the saturated code
    p_ovf_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (corr_value == '1 && !zero_flag));
    // R7: a full-scale sample overflows at every resolution
    p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_data == '1) |=> ovf_flag);
    // R6: a clamped result is zero
    p_zero_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> (corr_value == '0));
    // R9: flags only follow a sample above the smallest limit
    p_ovf_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> ($past(adc_data) >= SW'(256)));
    // R5: with no subtraction, a zero sample is the only way to clamp
    p_no_sub_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ped_en && adc_data != '0) |=> !zero_flag);
endmodule

// File: tb/ped_sub_unit_bench.sv
module ped_sub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic [3:0]  ch_addr = '0;
    logic [10:0] adc_data = '0;
    logic        ped_en = 1'b0;
    logic [1:0]  res_sel = 2'd3;
    logic [10:0] corr_value;
    logic        zero_flag, ovf_flag;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ped_sub_unit u_ped_sub_unit (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
        .ch_addr(ch_addr), .adc_data(adc_data), .ped_en(ped_en), .res_sel(res_sel),
        .corr_value(corr_value), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [1:0]  res;
        logic        en;
        logic [3:0]  ch;
        logic [10:0] adc;
        logic [10:0] exp_v;
        logic        exp_z;
        logic        exp_o;
    } vec_t;

    // pedestal of channel i is 10*i+5
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b1, 4'd2,  11'd100,  11'd75,   1'b0, 1'b0},  // R4
        '{2'd3, 1'b0, 4'd2,  11'd100,  11'd100,  1'b0, 1'b0},  // R5
        '{2'd3, 1'b1, 4'd2,  11'd25,   11'd0,    1'b1, 1'b0},  // R6 equal
        '{2'd3, 1'b1, 4'd2,  11'd24,   11'd0,    1'b1, 1'b0},  // R6 below
        '{2'd3, 1'b0, 4'd0,  11'd0,    11'd0,    1'b1, 1'b0},  // R6 zero sample
        '{2'd0, 1'b1, 4'd0,  11'd255,  11'd250,  1'b0, 1'b0},  // R7 8-bit
        '{2'd0, 1'b1, 4'd0,  11'd256,  11'd2047, 1'b0, 1'b1},  // R7
        '{2'd1, 1'b1, 4'd0,  11'd511,  11'd506,  1'b0, 1'b0},  // R7 9-bit
        '{2'd1, 1'b1, 4'd0,  11'd512,  11'd2047, 1'b0, 1'b1},  // R7
        '{2'd2, 1'b1, 4'd0,  11'd1023, 11'd1018, 1'b0, 1'b0},  // R7 10-bit
        '{2'd2, 1'b1, 4'd0,  11'd1024, 11'd2047, 1'b0, 1'b1},  // R7
        '{2'd3, 1'b1, 4'd0,  11'd1919, 11'd1914, 1'b0, 1'b0},  // R7 11-bit
        '{2'd3, 1'b1, 4'd0,  11'd1920, 11'd2047, 1'b0, 1'b1},  // R7
        '{2'd0, 1'b1, 4'd15, 11'd300,  11'd2047, 1'b0, 1'b1},  // R8 raw judged
        '{2'd3, 1'b1, 4'd15, 11'd2000, 11'd2047, 1'b0, 1'b1},  // R8
        '{2'd3, 1'b1, 4'd15, 11'd400,  11'd245,  1'b0, 1'b0}   // R4 top entry
    };

    task automatic check_out(input string req, input logic [10:0] ev,
                             input logic ez, input logic eo);
        checks++;
        if (corr_value !== ev || zero_flag !== ez || ovf_flag !== eo) begin
            fails++;
            $display("FAIL %s: value/zero/ovf got %0d/%0b/%0b expected %0d/%0b/%0b",
                     req, corr_value, zero_flag, ovf_flag, ev, ez, eo);
        end
    endtask

    task automatic check_host(input string req, input logic [7:0] ed, input logic ea);
        checks++;
        if (host_rdata !== ed || host_ack !== ea) begin
            fails++;
            $display("FAIL %s: rdata/ack got %0d/%0b expected %0d/%0b",
                     req, host_rdata, host_ack, ed, ea);
        end
    endtask

    task automatic host_op(input logic wr, input logic rd, input logic [3:0] a,
                           input logic [7:0] d);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic run(input logic [1:0] r, input logic e, input logic [3:0] c,
                       input logic [10:0] a);
        @(negedge clk);
        res_sel = r; ped_en = e; ch_addr = c; adc_data = a;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #5;
        check_out("R1", 11'd0, 1'b0, 1'b0);
        check_host("R1", 8'd0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        host_op(1'b0, 1'b1, 4'd7, 8'd0);
        // host_op returns one cycle after the request edge: read result visible now
        check_host("R1 entry cleared", 8'd0, 1'b1);

        // R2: load all pedestals in the ready state
        for (int i = 0; i < 16; i++) host_op(1'b1, 1'b0, 4'(i), 8'(10 * i + 5));
        host_op(1'b0, 1'b1, 4'd9, 8'd0);
        check_host("R2 read entry 9", 8'd95, 1'b1);
        host_op(1'b0, 1'b1, 4'd15, 8'd0);
        check_host("R2 read entry 15", 8'd155, 1'b1);

        // R3: busy refuses write and read
        busy = 1'b1;
        host_op(1'b1, 1'b0, 4'd3, 8'hAA);
        check_host("R3 write refused", 8'd0, 1'b0);
        host_op(1'b0, 1'b1, 4'd3, 8'd0);
        check_host("R3 read refused", 8'd0, 1'b0);
        busy = 1'b0;
        host_op(1'b0, 1'b1, 4'd3, 8'd0);
        check_host("R3 entry kept", 8'd35, 1'b1);

        // table walk
        for (int k = 0; k < NV; k++) begin
            run(VECS[k].res, VECS[k].en, VECS[k].ch, VECS[k].adc);
            check_out($sformatf("vector %0d (R4-R8 table)", k),
                      VECS[k].exp_v, VECS[k].exp_z, VECS[k].exp_o);
        end

        // R6 / R7 boundary with a 255 pedestal
        host_op(1'b1, 1'b0, 4'd1, 8'd255);
        run(2'd3, 1'b1, 4'd1, 11'd255);
        check_out("R6 pedestal 255 equal", 11'd0, 1'b1, 1'b0);
        run(2'd0, 1'b1, 4'd1, 11'd256);
        check_out("R7 pedestal 255 at limit", 11'd2047, 1'b0, 1'b1);

        // R9: inputs changed between edges do not show until the next edge
        run(2'd3, 1'b1, 4'd2, 11'd500);
        check_out("R9 settled", 11'd475, 1'b0, 1'b0);
        adc_data = 11'd600;
        #1;
        check_out("R9 before edge", 11'd475, 1'b0, 1'b0);
        @(negedge clk);
        check_out("R9 after edge", 11'd575, 1'b0, 1'b0);

        // R9: write and correction in the same cycle use the old pedestal
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'd2; host_wdata = 8'd100;
        ch_addr = 4'd2; adc_data = 11'd200; ped_en = 1'b1; res_sel = 2'd3;
        @(negedge clk);
        host_wr = 1'b0;
        check_out("R9 old pedestal used", 11'd175, 1'b0, 1'b0);
        @(negedge clk);
        check_out("R2 new pedestal used", 11'd100, 1'b0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule